// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Request Logic

This block keeps the status side of a serial peripheral interface controller. It holds three flags: one that shows the transmit buffer can take a new byte, one that shows a received byte was lost because the previous byte had not been read yet, and one that shows the slave-select pin was at the wrong level for the current role. It also holds the received byte that software reads and the byte waiting to be moved into the shifter. The shift engine supplies single-cycle pulses when it takes the buffered byte and when it completes a received byte. The host register interface supplies read and write strobes.

The error flags cannot be cleared by a single access. Software first reads the status register while the flag is set, which arms the clear. It then does a second, flag-specific access: a read of the receive data for the overflow flag, or a write of the control register for the mode-fault flag. If hardware raises the same flag again between the two accesses, the arm is dropped and the new event stays visible. When an overflow occurs, the held received byte is kept and the new byte is discarded. One registered, level-sensitive interrupt line combines a gated transmit request and a gated error request.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the transmit-empty flag is 1. The overflow flag, the mode-fault flag, both interrupt enables and the interrupt output are 0. The held receive byte and the transmit buffer are 0, and the receive holding register counts as empty.
- R2: A `shift_load` pulse sets the transmit-empty flag. A transmit write while the flag is 1 stores `txd_wdata` into the transmit buffer and clears the flag. If both occur in the same cycle, the write wins and the flag ends at 0.
- R3: A transmit write while the transmit-empty flag is 0 is ignored: the transmit buffer and the flag are unchanged.
- R4: A `byte_done` pulse while the holding register is empty loads `rx_byte` into `rx_data` and marks the register full. A receive read marks it empty. A read in the same cycle as `byte_done` is applied first, so the new byte loads without an overflow.
- R5: A `byte_done` pulse while the holding register is full and no receive read occurs sets the overflow flag and leaves `rx_data` unchanged.
- R6: The overflow flag clears only on a receive read that follows a status read made while the flag was 1. A receive read without that earlier status read leaves the flag set.
- R7: A new overflow event after the arming status read cancels the arm, so the next receive read does not clear the flag.
- R8: With `fault_det_en` at 1, a master (`is_master`=1) sets the mode-fault flag when `ss_n` falls from 1 to 0. A slave sets the flag when `ss_n` rises from 0 to 1 while `xfer_busy` is 1. The previous `ss_n` level is taken as 1 at reset. With `fault_det_en` at 0, the flag is never set.
- R9: The mode-fault flag clears only on a control write that follows a status read made while the flag was 1. A new fault event after that status read cancels the arm.
- R10: A control write loads the transmit interrupt enable from `ctrl_wdata` bit 0 and the error interrupt enable from bit 1.
- R11: `irq` is a register. Its value in a cycle equals, for the previous cycle, (transmit-empty AND transmit enable) OR (error enable AND (overflow OR mode fault)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_load | input | 1 | Pulse: the shift engine took the buffered transmit byte |
| byte_done | input | 1 | Pulse: a full byte has arrived in the shifter |
| rx_byte | input | DW | Byte just completed by the shifter |
| xfer_busy | input | 1 | A transfer is in progress |
| ss_n | input | 1 | Synchronised slave-select pin level |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| fault_det_en | input | 1 | Enables mode-fault detection |
| status_rd | input | 1 | Host read strobe of the status register |
| rxd_rd | input | 1 | Host read strobe of the receive data register |
| txd_wr | input | 1 | Host write strobe of the transmit data register |
| txd_wdata | input | DW | Transmit write data |
| ctrl_wr | input | 1 | Host write strobe of the control register |
| ctrl_wdata | input | 2 | Control write data: bit 0 transmit IE, bit 1 error IE |
| tx_buf | output | DW | Byte waiting for the shifter |
| rx_data | output | DW | Held received byte |
| txe_flag | output | 1 | Transmit buffer empty |
| ovr_flag | output | 1 | Receive overflow |
| fault_flag | output | 1 | Mode fault |
| irq | output | 1 | Registered interrupt request |

## Verification
The in-line assertions check, on every cycle, that a transmit write is dropped while the buffer is full and that an overflow freezes the held byte. They also check that each error flag can only fall one cycle after its own second-step access, that a mode fault can only rise with detection enabled, and that the interrupt stays low when both enables are off. Only the bench's scenarios can show the full two-step order. These include the arm being cancelled by a fresh overflow or fault, the pin-edge rules for each role, and the one-cycle lag of the interrupt against a reference model.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
    localparam int DATA_W        = 8;
    localparam int CTRL_W        = 2;
    localparam int CTRL_TXIE_BIT = 0;
    localparam int CTRL_ERIE_BIT = 1;

    typedef struct packed {
        logic flag;
        logic arm;
        logic ss_prev;
    } fault_st_t;

    typedef struct packed {
        logic txie;
        logic erie;
        logic irq;
    } irq_st_t;
endpackage

// File: rtl/txe_flag.sv
module txe_flag #(
    parameter int DW = spi_flag_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_load,
    input  logic          txd_wr,
    input  logic [DW-1:0] txd_wdata,
    output logic          txe,
    output logic [DW-1:0] tx_buf
);
    typedef struct packed {
        logic          empty;
        logic [DW-1:0] data;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   wr_ok;

    always_comb begin
        st_d  = st_q;
        wr_ok = txd_wr && st_q.empty;
        if (wr_ok) begin
            st_d.data  = txd_wdata;
            st_d.empty = 1'b0;
        end else if (shift_load) begin
            st_d.empty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.empty <= 1'b1;
            st_q.data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txe    = st_q.empty;
    assign tx_buf = st_q.data;

    AST_TX_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !txe) |=> $stable(tx_buf)); // R3
    AST_TX_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_load && !txd_wr) |=> txe); // R2
endmodule

// File: rtl/rx_overrun.sv
module rx_overrun #(
    parameter int DW = spi_flag_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          rxd_rd,
    input  logic          status_rd,
    output logic [DW-1:0] rx_data,
    output logic          ovr
);
    typedef struct packed {
        logic          full;
        logic          ovr;
        logic          arm;
        logic [DW-1:0] data;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   lost;

    always_comb begin
        st_d = st_q;
        lost = byte_done && st_q.full && !rxd_rd;
        if (rxd_rd) st_d.full = 1'b0;
        if (byte_done && !lost) begin
            st_d.data = rx_byte;
            st_d.full = 1'b1;
        end
        if (lost) begin
            st_d.ovr = 1'b1;
            st_d.arm = 1'b0;
        end else if (rxd_rd && st_q.arm) begin
            st_d.ovr = 1'b0;
            st_d.arm = 1'b0;
        end else if (status_rd && st_q.ovr) begin
            st_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_data = st_q.data;
    assign ovr     = st_q.ovr;

    AST_RX_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st_q.full && !rxd_rd) |=> ($stable(rx_data) && ovr)); // R5
    AST_OVR_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr) |-> $past(rxd_rd)); // R6
endmodule

// File: rtl/mode_fault.sv
module mode_fault
    import spi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n,
    input  logic xfer_busy,
    input  logic is_master,
    input  logic det_en,
    input  logic status_rd,
    input  logic ctrl_wr,
    output logic fault
);
    fault_st_t st_d, st_q;
    logic      ss_fall, ss_rise, hit;

    always_comb begin
        st_d    = st_q;
        ss_fall = st_q.ss_prev && !ss_n;
        ss_rise = !st_q.ss_prev && ss_n;
        hit     = det_en && (is_master ? ss_fall : (ss_rise && xfer_busy));
        st_d.ss_prev = ss_n;
        if (hit) begin
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end else if (ctrl_wr && st_q.arm) begin
            st_d.flag = 1'b0;
            st_d.arm  = 1'b0;
        end else if (status_rd && st_q.flag) begin
            st_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag    <= 1'b0;
            st_q.arm     <= 1'b0;
            st_q.ss_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.flag;

    AST_FAULT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(det_en)); // R8
    AST_FAULT_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(ctrl_wr)); // R9
endmodule

// File: rtl/irq_gen.sv
module irq_gen
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              txe,
    input  logic              ovr,
    input  logic              fault,
    output logic              irq
);
    irq_st_t st_d, st_q;
    logic    tx_req, err_req;

    always_comb begin
        st_d    = st_q;
        tx_req  = txe && st_q.txie;
        err_req = st_q.erie && (ovr || fault);
        st_d.irq = tx_req || err_req;
        if (ctrl_wr) begin
            st_d.txie = ctrl_wdata[CTRL_TXIE_BIT];
            st_d.erie = ctrl_wdata[CTRL_ERIE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.txie && !st_q.erie) |=> !irq); // R11
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.erie && !txe) |=> !irq); // R10
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_load,
    input  logic              byte_done,
    input  logic [DW-1:0]     rx_byte,
    input  logic              xfer_busy,
    input  logic              ss_n,
    input  logic              is_master,
    input  logic              fault_det_en,
    input  logic              status_rd,
    input  logic              rxd_rd,
    input  logic              txd_wr,
    input  logic [DW-1:0]     txd_wdata,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [DW-1:0]     tx_buf,
    output logic [DW-1:0]     rx_data,
    output logic              txe_flag,
    output logic              ovr_flag,
    output logic              fault_flag,
    output logic              irq
);
    txe_flag #(.DW(DW)) u_txe (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_load (shift_load),
        .txd_wr     (txd_wr),
        .txd_wdata  (txd_wdata),
        .txe        (txe_flag),
        .tx_buf     (tx_buf)
    );

    rx_overrun #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .rxd_rd    (rxd_rd),
        .status_rd (status_rd),
        .rx_data   (rx_data),
        .ovr       (ovr_flag)
    );

    mode_fault u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_n      (ss_n),
        .xfer_busy (xfer_busy),
        .is_master (is_master),
        .det_en    (fault_det_en),
        .status_rd (status_rd),
        .ctrl_wr   (ctrl_wr),
        .fault     (fault_flag)
    );

    irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .txe        (txe_flag),
        .ovr        (ovr_flag),
        .fault      (fault_flag),
        .irq        (irq)
    );

    AST_RESET_FLAGS: assert property (@(posedge clk)
        $rose(rst_n) |-> (txe_flag && !ovr_flag && !fault_flag)); // R1
endmodule

// File: tb/spi_flag_ctrl_test.sv
module spi_flag_ctrl_test;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_load = 0, byte_done = 0, xfer_busy = 0, ss_n = 1;
    logic is_master = 0, fault_det_en = 0, status_rd = 0, rxd_rd = 0;
    logic txd_wr = 0, ctrl_wr = 0;
    logic [DW-1:0] rx_byte = '0, txd_wdata = '0;
    logic [1:0] ctrl_wdata = '0;
    logic [DW-1:0] tx_buf, rx_data;
    logic txe_flag, ovr_flag, fault_flag, irq;

    int total = 0;
    int fails = 0;

    // reference model state
    logic m_txe = 1, m_full = 0, m_ovr = 0, m_oarm = 0, m_flt = 0, m_farm = 0;
    logic m_ssprev = 1, m_txie = 0, m_erie = 0, m_irq = 0;
    logic [DW-1:0] m_tx = '0, m_rx = '0;

    always #4 clk = ~clk;

    spi_flag_ctrl #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .shift_load(shift_load), .byte_done(byte_done),
        .rx_byte(rx_byte), .xfer_busy(xfer_busy), .ss_n(ss_n), .is_master(is_master),
        .fault_det_en(fault_det_en), .status_rd(status_rd), .rxd_rd(rxd_rd),
        .txd_wr(txd_wr), .txd_wdata(txd_wdata), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .tx_buf(tx_buf), .rx_data(rx_data),
        .txe_flag(txe_flag), .ovr_flag(ovr_flag), .fault_flag(fault_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic irq_next();
        return (m_txe && m_txie) || (m_erie && (m_ovr || m_flt));
    endfunction

    // one model step from the inputs present at the edge (R2..R11)
    task automatic model_step();
        logic lost, hit, n_irq;
        n_irq = irq_next();
        if (txd_wr && m_txe) begin m_tx = txd_wdata; m_txe = 0; end
        else if (shift_load) m_txe = 1;
        lost = byte_done && m_full && !rxd_rd;
        if (rxd_rd) m_full = 0;
        if (byte_done && !lost) begin m_rx = rx_byte; m_full = 1; end
        if (lost) begin m_ovr = 1; m_oarm = 0; end
        else if (rxd_rd && m_oarm) begin m_ovr = 0; m_oarm = 0; end
        else if (status_rd && m_ovr) m_oarm = 1;
        hit = fault_det_en && (is_master ? (m_ssprev && !ss_n)
                                         : (!m_ssprev && ss_n && xfer_busy));
        m_ssprev = ss_n;
        if (hit) begin m_flt = 1; m_farm = 0; end
        else if (ctrl_wr && m_farm) begin m_flt = 0; m_farm = 0; end
        else if (status_rd && m_flt) m_farm = 1;
        if (ctrl_wr) begin m_txie = ctrl_wdata[0]; m_erie = ctrl_wdata[1]; end
        m_irq = n_irq;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R2 txe", {7'd0, txe_flag}, {7'd0, m_txe});
        check("R3 tx_buf", tx_buf, m_tx);
        check("R4 rx_data", rx_data, m_rx);
        check("R5 ovr", {7'd0, ovr_flag}, {7'd0, m_ovr});
        check("R8 fault", {7'd0, fault_flag}, {7'd0, m_flt});
        check("R11 irq", {7'd0, irq}, {7'd0, m_irq});
        shift_load = 0; byte_done = 0; status_rd = 0; rxd_rd = 0;
        txd_wr = 0; ctrl_wr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 txe", {7'd0, txe_flag}, 8'd1);
        check("R1 ovr", {7'd0, ovr_flag}, 8'd0);
        check("R1 fault", {7'd0, fault_flag}, 8'd0);
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 rx_data", rx_data, 8'd0);
        check("R1 tx_buf", tx_buf, 8'd0);
        rst_n = 1;
        tick();

        // R2 / R3 transmit buffer
        txd_wr = 1; txd_wdata = 8'hA5; tick();
        check("R2 write accepted", tx_buf, 8'hA5);
        txd_wr = 1; txd_wdata = 8'h3C; tick();
        check("R3 write ignored", tx_buf, 8'hA5);
        shift_load = 1; tick();
        check("R2 load sets txe", {7'd0, txe_flag}, 8'd1);

        // R4 / R5 / R6 / R7 overflow
        byte_done = 1; rx_byte = 8'h11; tick();
        byte_done = 1; rx_byte = 8'h22; tick();
        check("R5 old byte kept", rx_data, 8'h11);
        check("R5 ovr set", {7'd0, ovr_flag}, 8'd1);
        rxd_rd = 1; tick();
        check("R6 read without arm", {7'd0, ovr_flag}, 8'd1);
        status_rd = 1; tick();
        byte_done = 1; rx_byte = 8'h33; tick();
        check("R4 loads when empty", rx_data, 8'h33);
        byte_done = 1; rx_byte = 8'h44; tick();
        rxd_rd = 1; tick();
        check("R7 arm cancelled", {7'd0, ovr_flag}, 8'd1);
        status_rd = 1; tick();
        rxd_rd = 1; tick();
        check("R6 two-step clear", {7'd0, ovr_flag}, 8'd0);

        // R8 / R9 / R10 / R11 mode fault
        ctrl_wr = 1; ctrl_wdata = 2'b10; tick();
        is_master = 1; fault_det_en = 1; tick();
        ss_n = 0; tick();
        check("R8 master fault", {7'd0, fault_flag}, 8'd1);
        tick();
        check("R10 err irq", {7'd0, irq}, 8'd1);
        ctrl_wr = 1; ctrl_wdata = 2'b10; tick();
        check("R9 write without arm", {7'd0, fault_flag}, 8'd1);
        status_rd = 1; tick();
        ctrl_wr = 1; ctrl_wdata = 2'b00; tick();
        check("R9 two-step clear", {7'd0, fault_flag}, 8'd0);
        tick();
        check("R11 irq drops", {7'd0, irq}, 8'd0);
        ss_n = 1; fault_det_en = 0; tick();
        ss_n = 0; tick();
        check("R8 detection off", {7'd0, fault_flag}, 8'd0);
        ss_n = 1; tick();

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            shift_load   = ($urandom % 4) == 0;
            byte_done    = ($urandom % 4) == 0;
            rx_byte      = DW'($urandom);
            status_rd    = ($urandom % 3) == 0;
            rxd_rd       = ($urandom % 4) == 0;
            txd_wr       = ($urandom % 4) == 0;
            txd_wdata    = DW'($urandom);
            ctrl_wr      = ($urandom % 6) == 0;
            ctrl_wdata   = 2'($urandom);
            if (($urandom % 5) == 0) ss_n = ~ss_n;
            xfer_busy    = ($urandom % 2) == 0;
            if (($urandom % 40) == 0) is_master = ~is_master;
            if (($urandom % 30) == 0) fault_det_en = ~fault_det_en;
            tick();
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule